// File: doc/BRIEF.md
# Trace Entry Writer with Late Payload Patching

This block owns the write side of a single-ported trace entry RAM. When a command is accepted for tracing, its header fields are written into the chosen entry in the same cycle, with the payload field cleared. Some commands carry a data phase that arrives later, in the same order as those commands. The block folds every valid beat of such a phase into one 8-bit payload (a byte mask or a length) and patches that payload into the entry the command went to.

A header write always owns the RAM port. A finished payload that cannot reach the RAM at once waits in a two-slot queue. That queue is emptied, oldest first, on cycles without a header write. When the queue is full and another payload must wait, the oldest waiting payload is dropped, its entry keeps a zero payload, and a one-cycle loss pulse is raised. A host read port shares the same RAM port and is granted only on cycles with no write.

The data-phase collector is a two-state machine. In `DP_IDLE`, a valid beat that is not last takes the transition *open* to `DP_ACCUM`, and a valid last beat takes *single-beat close*, which completes at once and stays in `DP_IDLE`. In `DP_ACCUM`, a valid beat that is not last takes *extend*, which stays in `DP_ACCUM`, and a valid last beat takes *close*, which returns to `DP_IDLE`. The port arbiter picks one owner for each cycle: `PS_HEADER`, `PS_DRAIN`, `PS_BYPASS` or `PS_IDLE`.

Top module: `trace_merge_writer`

## Requirements
- R1: A header request writes the whole entry in the same cycle: `ram_wr_en`=1, `ram_wr_patch`=0, `ram_wr_addr`=`hdr_idx`, and `ram_wr_data` = {8'h00, `hdr_fields`}, with the payload in bits [31:24] and the header in bits [23:0].
- R2: The payload of a data phase is the bitwise OR of `dat_bits` over all of its beats with `dat_valid`=1, up to and including the beat with `dat_last`=1. Beats with `dat_valid`=0 are ignored, whatever their `dat_last` value.
- R3: Data phases belong, in order, to header requests that had `hdr_has_data`=1. A header with `hdr_has_data`=0 never receives a payload patch.
- R4: If a payload completes on a cycle with no header request and an empty queue, it is written in that cycle: `ram_wr_patch`=1, `ram_wr_addr` = the owning entry, and `ram_wr_data[31:24]` = the payload with bits [23:0] zero.
- R5: A payload that completes during a header write is queued. On each cycle without a header request, the oldest queued payload is written as a patch.
- R6: If a payload completes on a cycle with no header request while the queue is not empty, the oldest queued payload is written and the new payload is queued behind the rest.
- R7: A payload queued while the queue already holds two entries, on a cycle with no drain, discards the oldest queued payload. `lost_pulse` is high for exactly that cycle, and the discarded entry keeps a zero payload.
- R8: The RAM port priority is header write, then queued or direct patch, then host read. `rd_grant` equals `rd_req` on cycles with no write and is 0 otherwise.
- R9: During and right after reset there is no write, the queue is empty, the collector is idle, and `rd_grant` follows `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_valid | input | 1 | Header write request this cycle |
| hdr_idx | input | 4 | Target entry of the header |
| hdr_fields | input | 24 | Header fields of the entry |
| hdr_has_data | input | 1 | A data phase will follow for this command |
| dat_valid | input | 1 | Data-phase beat valid |
| dat_last | input | 1 | Last beat of the data phase |
| dat_bits | input | 8 | Payload bits of the beat |
| rd_req | input | 1 | Host read wants the RAM port |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wr_patch | output | 1 | 1: write payload bits only; 0: write whole entry |
| ram_wr_addr | output | 4 | RAM write entry |
| ram_wr_data | output | 32 | {payload, header} write data |
| rd_grant | output | 1 | Host read owns the port this cycle |
| lost_pulse | output | 1 | A queued payload was discarded |

## Verification
Directed patterns isolate each port owner. A lone completion on a free port shows the direct patch. A completion under a header write shows queuing, and the next free cycle shows the drain. A completion on a free cycle with a non-empty queue shows the drain-then-queue order. Three completions under back-to-back headers show overwrite of the oldest payload. Beats with the valid flag low, including a stray last flag, separate true accumulation from naive OR-ing. A header without a data phase placed between two that have one shows that ownership follows command order. A long random mix, checked every cycle against a queue-based model, exercises overlaps that the directed cases do not reach.

// File: rtl/trace_merge_pkg.sv
package trace_merge_pkg;

    // owner of the single RAM port in a given cycle
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_HEADER = 2'd1,
        PS_BYPASS = 2'd2,
        PS_DRAIN  = 2'd3
    } port_sel_e;

    // data-phase collector states
    typedef enum logic {
        DP_IDLE  = 1'b0,
        DP_ACCUM = 1'b1
    } dp_state_e;

endpackage

// File: rtl/dp_collect.sv
module dp_collect
    import trace_merge_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int PAY_W      = 8,
    parameter int PEND_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_valid,
    input  logic             hdr_has_data,
    input  logic [IDX_W-1:0] hdr_idx,
    input  logic             dat_valid,
    input  logic             dat_last,
    input  logic [PAY_W-1:0] dat_bits,
    output logic             done_o,
    output logic [IDX_W-1:0] done_idx_o,
    output logic [PAY_W-1:0] done_pay_o
);
    localparam int PP_W  = $clog2(PEND_DEPTH);
    localparam int CNT_W = PP_W + 1;

    dp_state_e        state_q, state_d;
    logic [PAY_W-1:0] acc_q, acc_d;
    logic             done;
    logic [PAY_W-1:0] merged;

    // owners of outstanding data phases, in command order
    logic [IDX_W-1:0] pend_mem [PEND_DEPTH];
    logic [PP_W-1:0]  pend_rd_q;
    logic [CNT_W-1:0] pend_cnt_q;
    logic [PP_W-1:0]  pend_wr;
    logic             pend_full, pend_push, pend_pop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DP_IDLE;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        done    = 1'b0;
        merged  = '0;
        unique case (state_q)
            DP_IDLE: begin
                if (dat_valid) begin
                    if (dat_last) begin
                        done   = 1'b1;
                        merged = dat_bits;
                    end else begin
                        state_d = DP_ACCUM;
                        acc_d   = dat_bits;
                    end
                end
            end
            DP_ACCUM: begin
                if (dat_valid) begin
                    if (dat_last) begin
                        done    = 1'b1;
                        merged  = acc_q | dat_bits;
                        state_d = DP_IDLE;
                        acc_d   = '0;
                    end else begin
                        acc_d = acc_q | dat_bits;
                    end
                end
            end
            default: state_d = DP_IDLE;
        endcase
    end

    assign pend_full = (pend_cnt_q == CNT_W'(PEND_DEPTH));
    assign pend_pop  = done && (pend_cnt_q != '0);
    assign pend_push = hdr_valid && hdr_has_data && (!pend_full || pend_pop);
    assign pend_wr   = pend_rd_q + pend_cnt_q[PP_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_rd_q  <= '0;
            pend_cnt_q <= '0;
            for (int i = 0; i < PEND_DEPTH; i++) pend_mem[i] <= '0;
        end else begin
            if (pend_push) pend_mem[pend_wr] <= hdr_idx;
            if (pend_pop) pend_rd_q <= pend_rd_q + 1'b1;
            if (pend_push && !pend_pop)      pend_cnt_q <= pend_cnt_q + 1'b1;
            else if (pend_pop && !pend_push) pend_cnt_q <= pend_cnt_q - 1'b1;
        end
    end

    assign done_o     = done;
    assign done_idx_o = pend_mem[pend_rd_q];
    assign done_pay_o = merged;

    // R3: every completed phase has an owning command waiting
    assert_phase_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pend_cnt_q != '0));

    // R2: a beat with the valid flag low leaves the collector untouched
    assert_idle_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_valid |=> ($stable(acc_q) && $stable(state_q)));

endmodule

// File: rtl/ovw_fifo.sv
module ovw_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         lost
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] wr_slot;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    // when full, the low count bits are zero, so the write lands on the oldest slot
    assign wr_slot = rd_q + cnt_q[PTR_W-1:0];
    assign dout    = mem[rd_q];
    assign lost    = push && full && !pop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) mem[wr_slot] <= din;
            if (pop || lost) rd_q <= rd_q + 1'b1;
            if (push && !pop && !full)  cnt_q <= cnt_q + 1'b1;
            else if (pop && !push)      cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_drain_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    assert_loss_stays_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> full);

    assert_park_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty);

endmodule

// File: rtl/port_arb.sv
module port_arb
    import trace_merge_pkg::*;
(
    input  logic      hdr_valid,
    input  logic      done,
    input  logic      fifo_empty,
    input  logic      rd_req,
    output port_sel_e sel,
    output logic      push,
    output logic      pop,
    output logic      rd_grant
);
    always_comb begin
        if (hdr_valid)        sel = PS_HEADER;
        else if (!fifo_empty) sel = PS_DRAIN;
        else if (done)        sel = PS_BYPASS;
        else                  sel = PS_IDLE;
    end

    always_comb begin
        push     = 1'b0;
        pop      = 1'b0;
        rd_grant = 1'b0;
        unique case (sel)
            PS_HEADER: push = done;
            PS_DRAIN: begin
                pop  = 1'b1;
                push = done;
            end
            PS_BYPASS: ;
            PS_IDLE:   rd_grant = rd_req;
            default:   ;
        endcase
    end

endmodule

// File: rtl/trace_merge_writer.sv
module trace_merge_writer
    import trace_merge_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter int HDR_W      = 24,
    parameter int PAY_W      = 8,
    parameter int FIFO_DEPTH = 2,
    parameter int PEND_DEPTH = 4,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int ENTRY_W   = HDR_W + PAY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hdr_valid,
    input  logic [IDX_W-1:0]   hdr_idx,
    input  logic [HDR_W-1:0]   hdr_fields,
    input  logic               hdr_has_data,
    input  logic               dat_valid,
    input  logic               dat_last,
    input  logic [PAY_W-1:0]   dat_bits,
    input  logic               rd_req,
    output logic               ram_wr_en,
    output logic               ram_wr_patch,
    output logic [IDX_W-1:0]   ram_wr_addr,
    output logic [ENTRY_W-1:0] ram_wr_data,
    output logic               rd_grant,
    output logic               lost_pulse
);
    localparam int SLOT_W = IDX_W + PAY_W;

    logic             done;
    logic [IDX_W-1:0] done_idx;
    logic [PAY_W-1:0] done_pay;
    logic             f_push, f_pop, f_empty, f_full, f_lost;
    logic [SLOT_W-1:0] f_dout;
    port_sel_e        sel;

    dp_collect #(.IDX_W(IDX_W), .PAY_W(PAY_W), .PEND_DEPTH(PEND_DEPTH)) u_collect (
        .clk          (clk),
        .rst_n        (rst_n),
        .hdr_valid    (hdr_valid),
        .hdr_has_data (hdr_has_data),
        .hdr_idx      (hdr_idx),
        .dat_valid    (dat_valid),
        .dat_last     (dat_last),
        .dat_bits     (dat_bits),
        .done_o       (done),
        .done_idx_o   (done_idx),
        .done_pay_o   (done_pay)
    );

    port_arb u_arb (
        .hdr_valid  (hdr_valid),
        .done       (done),
        .fifo_empty (f_empty),
        .rd_req     (rd_req),
        .sel        (sel),
        .push       (f_push),
        .pop        (f_pop),
        .rd_grant   (rd_grant)
    );

    ovw_fifo #(.DEPTH(FIFO_DEPTH), .W(SLOT_W)) u_park (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f_push),
        .pop   (f_pop),
        .din   ({done_idx, done_pay}),
        .dout  (f_dout),
        .empty (f_empty),
        .full  (f_full),
        .lost  (f_lost)
    );

    assign lost_pulse = f_lost;

    always_comb begin
        ram_wr_en    = 1'b0;
        ram_wr_patch = 1'b0;
        ram_wr_addr  = '0;
        ram_wr_data  = '0;
        unique case (sel)
            PS_HEADER: begin
                ram_wr_en   = 1'b1;
                ram_wr_addr = hdr_idx;
                ram_wr_data = {{PAY_W{1'b0}}, hdr_fields};
            end
            PS_DRAIN: begin
                ram_wr_en    = 1'b1;
                ram_wr_patch = 1'b1;
                ram_wr_addr  = f_dout[SLOT_W-1:PAY_W];
                ram_wr_data  = {f_dout[PAY_W-1:0], {HDR_W{1'b0}}};
            end
            PS_BYPASS: begin
                ram_wr_en    = 1'b1;
                ram_wr_patch = 1'b1;
                ram_wr_addr  = done_idx;
                ram_wr_data  = {done_pay, {HDR_W{1'b0}}};
            end
            PS_IDLE: ;
            default: ;
        endcase
    end

    assert_header_owns_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (ram_wr_en && !ram_wr_patch && ram_wr_addr == hdr_idx));

    assert_read_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> !ram_wr_en);

    assert_loss_under_header_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lost_pulse |-> (hdr_valid && f_full));

    assert_grant_idle_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_valid && f_empty && !done) |-> (rd_grant == rd_req));

endmodule

// File: tb/trace_merge_writer_test.sv
`timescale 1ns/1ps
module trace_merge_writer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 0, hdr_has_data = 0, dat_valid = 0, dat_last = 0, rd_req = 0;
    logic [3:0]  hdr_idx = 0;
    logic [23:0] hdr_fields = 0;
    logic [7:0]  dat_bits = 0;
    logic        ram_wr_en, ram_wr_patch, rd_grant, lost_pulse;
    logic [3:0]  ram_wr_addr;
    logic [31:0] ram_wr_data;

    int checks = 0, failures = 0;
    bit finished = 0;

    // behavioural reference state
    int          pend[$];
    logic [11:0] park[$];
    bit          in_acc = 0;
    logic [7:0]  acc = 0;
    logic [31:0] mmem [16];
    logic [31:0] dmem [16];

    always #4 clk = ~clk;

    trace_merge_writer uut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_idx(hdr_idx),
        .hdr_fields(hdr_fields), .hdr_has_data(hdr_has_data), .dat_valid(dat_valid),
        .dat_last(dat_last), .dat_bits(dat_bits), .rd_req(rd_req),
        .ram_wr_en(ram_wr_en), .ram_wr_patch(ram_wr_patch), .ram_wr_addr(ram_wr_addr),
        .ram_wr_data(ram_wr_data), .rd_grant(rd_grant), .lost_pulse(lost_pulse)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic void apply_write(ref logic [31:0] m [16], input logic en, input logic pt,
                                        input logic [3:0] a, input logic [31:0] d);
        if (en) begin
            if (pt) m[a][31:24] = d[31:24];
            else    m[a] = d;
        end
    endfunction

    // one cycle: drive, compare against the model, then advance the model
    task automatic step(input logic hv, input logic [3:0] hi, input logic [23:0] hf, input logic hd,
                        input logic dv, input logic dl, input logic [7:0] db, input logic rq);
        logic        e_en, e_pt, e_gr, e_lost, done;
        logic [3:0]  e_a;
        logic [31:0] e_d;
        logic [7:0]  mpay;
        string       tag;
        hdr_valid = hv; hdr_idx = hi; hdr_fields = hf; hdr_has_data = hd;
        dat_valid = dv; dat_last = dl; dat_bits = db; rd_req = rq;
        #1;
        done = dv && dl;
        mpay = (in_acc ? acc : 8'h00) | db;
        e_en = 0; e_pt = 0; e_a = 0; e_d = 0; e_gr = 0; e_lost = 0;
        if (hv) begin
            e_en = 1; e_a = hi; e_d = {8'h00, hf}; tag = "R1";
            if (done) begin
                if (park.size() == 2) begin
                    e_lost = 1; tag = "R7";
                    void'(park.pop_front());
                end
                park.push_back({4'(pend[0]), mpay});
            end
        end else if (park.size() > 0) begin
            e_en = 1; e_pt = 1; e_a = park[0][11:8]; e_d = {park[0][7:0], 24'h0};
            tag = done ? "R6" : "R5";
            void'(park.pop_front());
            if (done) park.push_back({4'(pend[0]), mpay});
        end else if (done) begin
            e_en = 1; e_pt = 1; e_a = 4'(pend[0]); e_d = {mpay, 24'h0}; tag = "R4";
        end else begin
            e_gr = rq; tag = "R8";
        end
        check(tag, {22'h0, ram_wr_en, ram_wr_patch, ram_wr_addr, ram_wr_data, rd_grant, lost_pulse},
                   {22'h0, e_en, e_pt, e_a, e_d, e_gr, e_lost});
        apply_write(dmem, ram_wr_en, ram_wr_patch, ram_wr_addr, ram_wr_data);
        apply_write(mmem, e_en, e_pt, e_a, e_d);
        @(posedge clk);
        if (dv) begin
            if (dl) begin in_acc = 0; acc = 0; end
            else begin acc = mpay; in_acc = 1; end
        end
        if (done) void'(pend.pop_front());
        if (hv && hd) pend.push_back(int'(hi));
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin mmem[i] = 0; dmem[i] = 0; end
        rd_req = 1;
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state, no write and the read grant follows the request
        check("R9", {62'h0, ram_wr_en, rd_grant}, {62'h0, 1'b0, 1'b1});
        check("R9", {63'h0, lost_pulse}, 64'h0);
        @(negedge clk);
        rst_n = 1;
        idle(1);

        // R2 and R4: accumulate over valid beats, ignore an invalid stray last
        step(1, 4'd3, 24'hA00003, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 8'h01, 0);
        step(0, 0, 0, 0, 0, 1, 8'hFF, 0);
        step(0, 0, 0, 0, 1, 0, 8'h10, 0);
        step(0, 0, 0, 0, 1, 1, 8'h80, 1);
        check("R2", {56'h0, dmem[3][31:24]}, {56'h0, 8'h91});

        // R3: a header without data phase is skipped by ownership
        step(1, 4'd5, 24'hB00005, 0, 0, 0, 0, 0);
        step(1, 4'd6, 24'hB00006, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 1, 8'h42, 0);
        check("R3", {48'h0, dmem[5][31:24], dmem[6][31:24]}, {48'h0, 8'h00, 8'h42});

        // R5: completion under a header is parked, then drained
        step(1, 4'd1, 24'hC00001, 1, 0, 0, 0, 0);
        step(1, 4'd2, 24'hC00002, 1, 0, 0, 0, 0);
        step(1, 4'd9, 24'hC00009, 0, 1, 1, 8'h0F, 1);
        // R6: drain and park on a free cycle
        step(0, 0, 0, 0, 1, 1, 8'hF0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle(1);
        check("R5", {48'h0, dmem[1][31:24], dmem[2][31:24]}, {48'h0, 8'h0F, 8'hF0});

        // R7: three completions under back-to-back headers lose the oldest
        step(1, 4'd10, 24'hD0000A, 1, 0, 0, 0, 0);
        step(1, 4'd11, 24'hD0000B, 1, 0, 0, 0, 0);
        step(1, 4'd12, 24'hD0000C, 1, 0, 0, 0, 0);
        step(1, 4'd13, 24'hD0000D, 0, 1, 1, 8'h11, 1);
        step(1, 4'd14, 24'hD0000E, 0, 1, 1, 8'h22, 1);
        step(1, 4'd15, 24'hD0000F, 0, 1, 1, 8'h33, 1);
        idle(3);
        check("R7", {40'h0, dmem[10][31:24], dmem[11][31:24], dmem[12][31:24]},
                    {40'h0, 8'h00, 8'h22, 8'h33});

        // random mix against the model (R8 grants included)
        for (int n = 0; n < 600; n++) begin
            logic hv, hd, dv, dl;
            hv = ($urandom % 2) == 0;
            hd = hv && (pend.size() < 4) && (($urandom % 2) == 0);
            dv = (pend.size() > 0) && (($urandom % 5) < 3);
            dl = ($urandom % 5) < 2;
            step(hv, 4'($urandom), 24'($urandom), hd, dv, dl, 8'($urandom), 1'($urandom));
        end
        while (pend.size() > 0) step(0, 0, 0, 0, 1, 1, 8'($urandom), 0);
        idle(3);
        for (int i = 0; i < 16; i++) check("R5", {32'h0, dmem[i]}, {32'h0, mmem[i]});

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule